// File: doc/BRIEF.md
# SD Card Clock Generator

This block derives the clock sent to an SD card from the host reference clock. A 17-bit control word, loaded through a simple write strobe, picks a power-of-two divide ratio. A one-hot byte field covers ratios from 1/4 to 1/512, and an empty byte gives 1/2. Two extension bits select straight pass-through and 1/1024.

A run bit gates the card clock. An auto-idle bit can also hold the clock low whenever the command and data engines report the bus idle. Gating always waits for the low phase of the divided clock, so the card never sees a shortened high pulse. A new ratio is adopted only after software has cleared the run bit and the clock has actually stopped. The divider counter restarts at that moment, so the first period after re-enabling is full length.

Top module: `sd_card_clkgen`

## Requirements
- R1: In the byte field (control bits 7..0), the highest set bit i gives a divide ratio of 2^(i+2): bit 0 divides by 4, bit 7 by 512, and lower set bits are ignored.
- R2: With bits 7..0 clear and bits 10 and 16 clear, the ratio is 1/2.
- R3: Bit 10 selects pass-through. The card clock is high during each high phase of the reference clock and low during each low phase. It wins over bit 16 and over the byte field.
- R4: Bit 16 selects 1/1024. It wins over the byte field.
- R5: Bit 8 is the run bit. When it is clear, the card clock is held low. Clearing it while the clock is high lets the current high phase finish first.
- R6: A ratio written while the run bit is set has no effect until the run bit has been cleared and the clock has stopped. The running clock keeps its old period.
- R7: After the clock starts, it is low for exactly half a period of reference cycles and then high for half a period. The first period is full length.
- R8: Bit 9 enables auto-idle. While it is set and bus_busy is low, the clock stops at its next low phase and stays low. When bus_busy rises, the clock restarts as in R7.
- R9: For every ratio of 1/2 or slower, each high pulse lasts exactly half a period and each low interval lasts at least half a period.
- R10: While rst is high, and after it until the run bit is set, the card clock is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host reference clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_we | input | 1 | Loads ctl_wdata into the control word |
| ctl_wdata | input | 17 | Control word: ratio byte [7:0], run [8], auto-idle [9], pass-through [10], 1/1024 [16] |
| bus_busy | input | 1 | High while the command or data engine needs the clock |
| card_clk | output | 1 | Gated, divided clock to the card |

## Verification
The bench sweeps every ratio from pass-through to 1/1024 and compares the sampled waveform with a pattern computed from the half period. A design whose counter did not restart on enable would show a short first low phase. A priority inversion between the extension bits and the byte would produce the wrong period. A monitor measures every pulse, which catches a gate that drops mid-high or a ratio that changes while running. The auto-idle test and a retargeting attempt while running show whether gating waits for the low phase and whether the ratio latch waits for the stop.

// File: rtl/sdclk_pkg.sv
package sdclk_pkg;
  localparam int SEL_W = 8;

  typedef struct packed {
    logic             div1024;
    logic [4:0]       rsvd;
    logic             bypass;
    logic             auto_idle;
    logic             run;
    logic [SEL_W-1:0] sel;
  } ctl_t;

  localparam int CTL_W = $bits(ctl_t);
  localparam int EXP_MAX = SEL_W + 2;
  localparam int EXP_W = $clog2(EXP_MAX + 1);
endpackage

// File: rtl/sdclk_ratio_dec.sv
module sdclk_ratio_dec
  import sdclk_pkg::*;
#(
  parameter int SEL_BITS = SEL_W,
  localparam int EW = $clog2(SEL_BITS + 3)
) (
  input  ctl_t          ctl,
  output logic [EW-1:0] ratio_exp
);
  logic [EW-1:0] byte_exp;

  always_comb begin
    byte_exp = EW'(1);
    for (int i = 0; i < SEL_BITS; i++) begin
      if (ctl.sel[i]) byte_exp = EW'(i + 2);
    end
    if (ctl.bypass)       ratio_exp = '0;
    else if (ctl.div1024) ratio_exp = EW'(SEL_BITS + 2);
    else                  ratio_exp = byte_exp;
  end
endmodule

// File: rtl/sdclk_ctl_reg.sv
module sdclk_ctl_reg
  import sdclk_pkg::*;
#(
  parameter int SEL_BITS = SEL_W,
  localparam int EW = $clog2(SEL_BITS + 3)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [CTL_W-1:0] wdata,
  input  logic             gate_on,
  output ctl_t             ctl_q,
  output logic [EW-1:0]    ratio_q
);
  logic [EW-1:0] ratio_nxt;
  logic          unused_rsvd;

  assign unused_rsvd = ^ctl_q.rsvd;

  sdclk_ratio_dec #(.SEL_BITS(SEL_BITS)) u_dec (
    .ctl       (ctl_q),
    .ratio_exp (ratio_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q   <= '0;
      ratio_q <= EW'(1);
    end else begin
      if (we) ctl_q <= ctl_t'(wdata);
      if (!ctl_q.run && !gate_on) ratio_q <= ratio_nxt;
    end
  end

  a_r6_ratio_frozen: assert property (@(posedge clk) disable iff (rst)
    ($past(gate_on) || $past(ctl_q.run)) |-> $stable(ratio_q));

  a_r3_bypass_wins: assert property (@(posedge clk) disable iff (rst)
    (!ctl_q.run && !gate_on && ctl_q.bypass) |=> (ratio_q == '0));

  a_r4_div1024_over_byte: assert property (@(posedge clk) disable iff (rst)
    (!ctl_q.run && !gate_on && !ctl_q.bypass && ctl_q.div1024)
      |=> (ratio_q == EW'(SEL_BITS + 2)));
endmodule

// File: rtl/sdclk_divider.sv
module sdclk_divider
  import sdclk_pkg::*;
#(
  parameter int SEL_BITS = SEL_W,
  localparam int EW = $clog2(SEL_BITS + 3),
  localparam int HALF_W = SEL_BITS + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          want_on,
  input  logic [EW-1:0] ratio,
  output logic          gate_q,
  output logic          div_q
);
  logic [HALF_W:0]   half_full;
  logic [HALF_W-1:0] half_m1;
  logic [HALF_W-1:0] cnt_q;

  always_comb begin
    half_full = (HALF_W+1)'(1);
    if (ratio != '0) half_full = (HALF_W+1)'(1) << (ratio - EW'(1));
    half_m1 = HALF_W'(half_full - (HALF_W+1)'(1));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      gate_q <= 1'b0;
      div_q  <= 1'b0;
      cnt_q  <= '0;
    end else if (!gate_q) begin
      div_q <= 1'b0;
      cnt_q <= '0;
      if (want_on) gate_q <= 1'b1;
    end else if (!want_on && !div_q) begin
      gate_q <= 1'b0;
      cnt_q  <= '0;
    end else if (ratio == '0) begin
      cnt_q <= '0;
    end else if (cnt_q == half_m1) begin
      cnt_q <= '0;
      div_q <= ~div_q;
    end else begin
      cnt_q <= cnt_q + HALF_W'(1);
    end
  end

  a_r10_reset_low: assert property (@(posedge clk)
    rst |=> (!div_q && !gate_q));

  a_r9_stop_in_low: assert property (@(posedge clk) disable iff (rst)
    $fell(gate_q) |-> !$past(div_q));

  a_r5_rise_needs_gate: assert property (@(posedge clk) disable iff (rst)
    $rose(div_q) |-> $past(gate_q));

  a_r7_fresh_start: assert property (@(posedge clk) disable iff (rst)
    $rose(gate_q) |-> (!div_q && cnt_q == '0));
endmodule

// File: rtl/sd_card_clkgen.sv
module sd_card_clkgen
  import sdclk_pkg::*;
#(
  parameter int SEL_BITS = SEL_W,
  localparam int EW = $clog2(SEL_BITS + 3)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ctl_we,
  input  logic [CTL_W-1:0] ctl_wdata,
  input  logic             bus_busy,
  output logic             card_clk
);
  ctl_t          ctl_q;
  logic [EW-1:0] ratio_q;
  logic          gate_q;
  logic          div_q;
  logic          want_on;
  logic          thru_en_q;

  assign want_on = ctl_q.run && !(ctl_q.auto_idle && !bus_busy);

  sdclk_ctl_reg #(.SEL_BITS(SEL_BITS)) u_ctl (
    .clk     (clk),
    .rst     (rst),
    .we      (ctl_we),
    .wdata   (ctl_wdata),
    .gate_on (gate_q),
    .ctl_q   (ctl_q),
    .ratio_q (ratio_q)
  );

  sdclk_divider #(.SEL_BITS(SEL_BITS)) u_div (
    .clk     (clk),
    .rst     (rst),
    .want_on (want_on),
    .ratio   (ratio_q),
    .gate_q  (gate_q),
    .div_q   (div_q)
  );

  // Pass-through enable changes only while clk is low.
  always_ff @(negedge clk) begin
    if (rst) thru_en_q <= 1'b0;
    else     thru_en_q <= gate_q && (ratio_q == '0);
  end

  assign card_clk = (ratio_q == '0) ? (clk & thru_en_q) : div_q;

  a_r8_idle_stops: assert property (@(posedge clk) disable iff (rst)
    (gate_q && !div_q && ctl_q.auto_idle && !bus_busy) |=> !gate_q);

  a_r5_run_clear_stops: assert property (@(posedge clk) disable iff (rst)
    (gate_q && !div_q && !ctl_q.run) |=> !gate_q);
endmodule

// File: tb/tb_sd_card_clkgen.sv
module tb_sd_card_clkgen;
  localparam int RUN  = 1 << 8;
  localparam int AUTO = 1 << 9;
  localparam int THRU = 1 << 10;
  localparam int D1K  = 1 << 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ctl_we = 1'b0;
  logic [16:0] ctl_wdata = '0;
  logic        bus_busy = 1'b0;
  logic        card_clk;

  int checks = 0;
  int errors = 0;
  int mon_h = 0;
  bit mon_on = 1'b0;

  always #4 clk = ~clk;

  sd_card_clkgen dut (
    .clk(clk), .rst(rst), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .bus_busy(bus_busy), .card_clk(card_clk)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(input int v);
    @(negedge clk);
    ctl_we = 1'b1;
    ctl_wdata = 17'(v);
    @(negedge clk);
    ctl_we = 1'b0;
  endtask

  task automatic expect_pattern(input int h, input int n, input string tag);
    int bad = 0;
    int first = -1;
    int got = 0;
    int exp = 0;
    for (int i = 1; i <= n; i++) begin
      @(posedge clk); #2;
      if (card_clk !== (((i - 1) / h) % 2 == 1)) begin
        if (first < 0) begin
          first = i;
          got = int'(card_clk);
          exp = ((i - 1) / h) % 2;
        end
        bad++;
      end
    end
    check(bad == 0, tag, got, exp);
  endtask

  task automatic expect_low(input int n, input string tag);
    int highs = 0;
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #2;
      if (card_clk !== 1'b0) highs++;
    end
    check(highs == 0, tag, highs, 0);
  endtask

  task automatic stop_and_wait(input int v, input int h);
    wr(v);
    repeat (2 * h + 4) @(posedge clk);
  endtask

  // Pulse-width monitor for ratios of 1/2 and slower
  bit mprev;
  bit mseen;
  bit mfull;
  int mlen;
  always @(posedge clk) begin
    #2;
    if (!mon_on) begin
      mseen = 1'b0;
      mfull = 1'b0;
      mlen = 0;
    end else if (!mseen) begin
      mseen = 1'b1;
      mprev = card_clk;
      mlen = 1;
    end else if (card_clk == mprev) begin
      mlen++;
    end else begin
      if (mfull && mon_h > 0) begin
        if (mprev) check(mlen == mon_h, "R9 high pulse width", mlen, mon_h);
        else       check(mlen >= mon_h, "R9 low interval width", mlen, mon_h);
      end
      mfull = 1'b1;
      mprev = card_clk;
      mlen = 1;
    end
  end

  initial begin
    #(8 * 190000);
    errors++;
    $display("FAIL watchdog actual 0 expected 1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int hw;
    bit seen;
    // R10: low while in reset and after it
    repeat (3) @(posedge clk);
    #2 check(card_clk === 1'b0, "R10 low in reset", int'(card_clk), 0);
    @(negedge clk); rst = 1'b0;
    expect_low(10, "R10 low after reset, run clear");

    // R1 R2 R4 R7: sweep every divided ratio
    mon_on = 1'b1;
    for (int k = 1; k <= 10; k++) begin
      int v = (k == 1) ? 0 : ((k == 10) ? D1K : (1 << (k - 2)));
      int h = 1 << (k - 1);
      mon_h = h;
      wr(v);
      wr(v | RUN);
      if (k == 1)       expect_pattern(h, 4 * h, "R2 divide by 2 with full first period R7");
      else if (k == 10) expect_pattern(h, 4 * h, "R4 divide by 1024 with full first period R7");
      else              expect_pattern(h, 4 * h, "R1 byte ratio with full first period R7");
      stop_and_wait(v, h);
      expect_low(8, "R5 held low after run clear");
    end

    // R4: 1/1024 wins over byte; R1: highest byte bit wins
    mon_h = 512;
    wr(D1K | 8'h81);
    wr(D1K | 8'h81 | RUN);
    expect_pattern(512, 1024, "R4 priority over byte field");
    stop_and_wait(D1K | 8'h81, 512);
    mon_h = 8;
    wr(8'h05);
    wr(8'h05 | RUN);
    expect_pattern(8, 32, "R1 highest set bit selects 1/16");
    stop_and_wait(8'h05, 8);

    // R6: retarget while running has no effect
    mon_h = 4;
    wr(8'h02);
    wr(8'h02 | RUN);
    expect_pattern(4, 16, "R6 base ratio 1/8");
    wr(8'h80 | RUN);
    seen = 1'b0;
    for (int i = 0; i < 40 && !seen; i++) begin
      @(posedge clk); #2;
      if (card_clk) seen = 1'b1;
    end
    hw = 1;
    for (int i = 0; i < 600; i++) begin
      @(posedge clk); #2;
      if (!card_clk) break;
      hw++;
    end
    check(seen && hw == 4, "R6 old ratio kept while running", hw, 4);
    stop_and_wait(8'h80, 4);
    mon_h = 256;
    wr(8'h80 | RUN);
    expect_pattern(256, 512, "R6 new ratio after stop");
    stop_and_wait(8'h80, 256);

    // R8: auto-idle
    mon_h = 4;
    wr(8'h02);
    wr(8'h02 | RUN | AUTO);
    expect_low(16, "R8 idle bus holds clock low");
    @(negedge clk); bus_busy = 1'b1;
    expect_pattern(4, 18, "R8 busy restarts clock");
    @(negedge clk); bus_busy = 1'b0;
    repeat (12) @(posedge clk);
    expect_low(12, "R8 stop after bus goes idle");
    @(negedge clk); bus_busy = 1'b1;
    expect_pattern(4, 16, "R8 second restart full period");
    @(negedge clk); bus_busy = 1'b0;
    stop_and_wait(8'h02, 4);

    // R3: pass-through wins over everything
    mon_on = 1'b0;
    wr(THRU | D1K | 8'hFF);
    wr(THRU | D1K | 8'hFF | RUN);
    @(posedge clk); #2;
    check(card_clk === 1'b0, "R3 first sample before enable lands", int'(card_clk), 0);
    begin
      int hi_bad = 0;
      int lo_bad = 0;
      for (int i = 0; i < 8; i++) begin
        @(posedge clk); #2;
        if (card_clk !== 1'b1) hi_bad++;
        @(negedge clk); #2;
        if (card_clk !== 1'b0) lo_bad++;
      end
      check(hi_bad == 0, "R3 follows clk high phase", hi_bad, 0);
      check(lo_bad == 0, "R3 follows clk low phase", lo_bad, 0);
    end
    stop_and_wait(THRU | D1K | 8'hFF, 1);
    expect_low(8, "R5 pass-through stopped");

    // R10: reset while running
    wr(0);
    wr(RUN);
    repeat (5) @(posedge clk);
    @(negedge clk); rst = 1'b1;
    @(posedge clk); #2;
    check(card_clk === 1'b0, "R10 reset forces low", int'(card_clk), 0);
    @(negedge clk); rst = 1'b0;
    expect_low(8, "R10 run cleared by reset");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule